// File: doc/BRIEF.md
# Center-Aligned Up/Down Timer with Period Match

This block is a 16-bit timer for center-aligned PWM. It counts up from zero until it reaches an active period value. It then steps one count further, to period+1, turns around and counts back down to zero. After that it starts counting up again. A new period value is held in a shadow register. The shadow value moves into the active register when the up-count matches the period, so a period change never lands in the middle of a half-cycle.

The turnaround passes through the period value twice in each cycle. The block gives two kinds of period event. The external trigger pulses on both passes through the crest value. The internal period-match pulse fires only on the rising pass, and the shadow-transfer strobe fires with it. Downstream interrupt logic therefore sees one event per cycle, and a converter trigger wired to the external pulse sees two. Every pin is plain control or status, and no pin uses a valid/ready handshake: the block consumes a count enable on every cycle it is offered and cannot apply back-pressure.

Top module: `updown_pwm_timer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `count` is 0, `dir_down` is 0 and all three pulses are 0. The active period and the shadow period both take the parameter `RESET_PERIOD` (default 0x0010).
- R2: An advance while rising adds one to `count`. When the count lands on the active period P, the next advance goes to P+1 and the advance after that returns to P. With P = 0x200 the counts run 0x1FE, 0x1FF, 0x200, 0x201, 0x200, 0x1FF, 0x1FE. Supported periods are 1 to 0xFFFE.
- R3: `dir_down` is 0 while rising, including at P and at P+1. It becomes 1 with the step from P+1 back to P. Each advance while falling subtracts one. The step that lands on 0 sets `dir_down` back to 0.
- R4: `ext_trig` is high for the cycle after each landing on the crest value: once on the rising step onto P, and once on the falling step from P+1 back to P.
- R5: `pm_up` is high only for the cycle after the rising landing on P, so it pulses once per count cycle.
- R6: A write with `per_wr` high loads `per_wdata` into the shadow period. `shadow_xfer` pulses together with `pm_up`, and on that same edge the shadow value becomes the active period. A shadow write on the transfer edge takes effect only at the next transfer.
- R7: The timer advances only on edges where both `run` and `cnt_en` are 1. On any other edge, `count` and `dir_down` hold their values.
- R8: Every pulse is one clock wide. It appears in the same cycle as the count value that caused it, and it is 0 after any edge without an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run bit; 0 freezes the timer |
| cnt_en | input | 1 | Count enable, one advance per high cycle |
| per_wr | input | 1 | Shadow period write strobe |
| per_wdata | input | 16 | Shadow period write value |
| count | output | 16 | Current count |
| dir_down | output | 1 | 1 while counting down |
| ext_trig | output | 1 | Crest-value pulse on both passes |
| pm_up | output | 1 | Period-match pulse, rising pass only |
| shadow_xfer | output | 1 | Shadow-to-active transfer strobe |

## Verification
A directed run loads a period of 0x200 through the shadow register. It then follows the counts across the crest and checks the two external pulses against the single internal one, which separates the two event paths. Held-off phases, with `run` low or `cnt_en` low, show whether the timer really freezes and whether the pulses drop to 0. A long constrained-random phase mixes sparse enables with frequent shadow writes of small periods, including period 1. These writes sometimes land on a transfer edge, so the phase exercises the shadow timing and the turnaround at the smallest legal crest.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    PH_RISE  = 2'd0,
    PH_CREST = 2'd1,
    PH_PEAK  = 2'd2,
    PH_FALL  = 2'd3
  } tmr_phase_e;
endpackage

// File: rtl/tmr_period_regs.sv
module tmr_period_regs #(
  parameter int unsigned           W            = 16,
  parameter logic [W-1:0]          RESET_PERIOD = 16'h0010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         xfer,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;

  // the transfer always takes the value held before this edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= RESET_PERIOD;
      active_q <= RESET_PERIOD;
    end else begin
      if (wr)   shadow_q <= wdata;
      if (xfer) active_q <= shadow_q;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         dir_down,
  output logic         hit_rise,
  output logic         hit_peak
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  tmr_phase_e   ph_q, ph_nx;
  logic [W-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx   = cnt_q;
    ph_nx    = ph_q;
    hit_rise = 1'b0;
    hit_peak = 1'b0;
    if (advance) begin
      unique case (ph_q)
        PH_RISE: begin
          cnt_nx = cnt_q + ONE;
          if (cnt_nx == period) begin
            hit_rise = 1'b1;
            ph_nx    = PH_CREST;
          end
        end
        PH_CREST: begin
          cnt_nx = cnt_q + ONE;
          ph_nx  = PH_PEAK;
        end
        PH_PEAK: begin
          cnt_nx   = cnt_q - ONE;
          ph_nx    = PH_FALL;
          hit_peak = 1'b1;
        end
        PH_FALL: begin
          cnt_nx = cnt_q - ONE;
          if (cnt_nx == '0) ph_nx = PH_RISE;
        end
        default: ph_nx = PH_RISE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_RISE;
    end else begin
      cnt_q <= cnt_nx;
      ph_q  <= ph_nx;
    end
  end

  assign count    = cnt_q;
  assign dir_down = (ph_q == PH_FALL);
endmodule

// File: rtl/tmr_event_gen.sv
module tmr_event_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_rise,
  input  logic hit_peak,
  output logic ext_trig,
  output logic pm_up,
  output logic shadow_xfer
);
  logic ext_q, pm_q, xf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      pm_q  <= 1'b0;
      xf_q  <= 1'b0;
    end else begin
      ext_q <= hit_rise | hit_peak;
      pm_q  <= hit_rise;
      xf_q  <= hit_rise;
    end
  end

  assign ext_trig    = ext_q;
  assign pm_up       = pm_q;
  assign shadow_xfer = xf_q;
endmodule

// File: rtl/updown_pwm_timer.sv
module updown_pwm_timer #(
  parameter int unsigned  W            = 16,
  parameter logic [W-1:0] RESET_PERIOD = 16'h0010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cnt_en,
  input  logic         per_wr,
  input  logic [W-1:0] per_wdata,
  output logic [W-1:0] count,
  output logic         dir_down,
  output logic         ext_trig,
  output logic         pm_up,
  output logic         shadow_xfer
);
  logic         advance;
  logic [W-1:0] period_act;
  logic         hit_rise, hit_peak;

  assign advance = run & cnt_en;

  tmr_period_regs #(.W(W), .RESET_PERIOD(RESET_PERIOD)) u_per (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (per_wr),
    .wdata  (per_wdata),
    .xfer   (hit_rise),
    .active (period_act)
  );

  tmr_count_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .period   (period_act),
    .count    (count),
    .dir_down (dir_down),
    .hit_rise (hit_rise),
    .hit_peak (hit_peak)
  );

  tmr_event_gen u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_rise    (hit_rise),
    .hit_peak    (hit_peak),
    .ext_trig    (ext_trig),
    .pm_up       (pm_up),
    .shadow_xfer (shadow_xfer)
  );
endmodule

// File: rtl/updown_pwm_timer_chk.sv
module updown_pwm_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         cnt_en,
  input logic [W-1:0] count,
  input logic         dir_down,
  input logic         ext_trig,
  input logic         pm_up,
  input logic         shadow_xfer
);
  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && cnt_en) |=> ($stable(count) && $stable(dir_down)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && cnt_en) |=> (!ext_trig && !pm_up && !shadow_xfer));

  // R8
  one_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_trig || pm_up) |=> (!ext_trig && !pm_up));

  // R5
  pm_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_up |-> (ext_trig && !dir_down));

  // R6
  xfer_with_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_xfer |-> pm_up);

  // R3
  up_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_down) |-> (count == '0));

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en) |=> ((count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)));
endmodule

bind updown_pwm_timer updown_pwm_timer_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .cnt_en      (cnt_en),
  .count       (count),
  .dir_down    (dir_down),
  .ext_trig    (ext_trig),
  .pm_up       (pm_up),
  .shadow_xfer (shadow_xfer)
);

// File: tb/updown_pwm_timer_test.sv
module updown_pwm_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RST_PER = 16'h0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, cnt_en = 1'b0, per_wr = 1'b0;
  logic [15:0] per_wdata = '0;
  logic [15:0] count;
  logic dir_down, ext_trig, pm_up, shadow_xfer;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state: 0 rise, 1 at crest, 2 at crest+1, 3 fall
  int m_ph;
  logic [15:0] m_cnt, m_per, m_sh;
  logic m_ext, m_pm, m_xf;

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt_en(cnt_en),
    .per_wr(per_wr), .per_wdata(per_wdata),
    .count(count), .dir_down(dir_down), .ext_trig(ext_trig),
    .pm_up(pm_up), .shadow_xfer(shadow_xfer)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic model_edge(bit adv, bit wr, logic [15:0] wd);
    logic [15:0] old_sh;
    old_sh = m_sh;
    m_ext = 0; m_pm = 0; m_xf = 0;
    if (adv) begin
      case (m_ph)
        0: begin
          m_cnt = m_cnt + 16'd1;
          if (m_cnt == m_per) begin
            m_ext = 1; m_pm = 1; m_xf = 1; m_per = old_sh; m_ph = 1;
          end
        end
        1: begin m_cnt = m_cnt + 16'd1; m_ph = 2; end
        2: begin m_cnt = m_cnt - 16'd1; m_ph = 3; m_ext = 1; end
        default: begin
          m_cnt = m_cnt - 16'd1;
          if (m_cnt == 16'd0) m_ph = 0;
        end
      endcase
    end
    if (wr) m_sh = wd;
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step(bit r, bit e, bit w, logic [15:0] d);
    bit adv;
    adv = r && e;
    run = r; cnt_en = e; per_wr = w; per_wdata = d;
    @(posedge clk);
    model_edge(adv, w, d);
    @(negedge clk);
    if (adv) begin
      chk("R2 count", count, m_cnt);
      chk("R3 dir_down", dir_down, (m_ph == 3));
      chk("R4 ext_trig", ext_trig, m_ext);
      chk("R5 pm_up", pm_up, m_pm);
      chk("R6 shadow_xfer", shadow_xfer, m_xf);
    end else begin
      chk("R7 count frozen", count, m_cnt);
      chk("R7 dir frozen", dir_down, (m_ph == 3));
      chk("R8 pulses idle", {ext_trig, pm_up, shadow_xfer}, 3'b000);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [15:0] exp_c [6];
    bit exp_e [6];
    bit exp_p [6];
    int guard;
    void'($urandom(32'd4242));
    m_ph = 0; m_cnt = 0; m_per = RST_PER; m_sh = RST_PER;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, 16'h0);
    chk("R1 pulses in reset", {dir_down, ext_trig, pm_up, shadow_xfer}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after reset", count, 16'h0);
    chk("R1 dir/pulses after reset", {dir_down, ext_trig, pm_up, shadow_xfer}, 4'b0000);

    // load 0x200 into shadow, then run through the reset period first
    step(1, 0, 1, 16'h0200);
    guard = 0;
    while (!(m_cnt == 16'h01FE && m_ph == 0) && guard < 5000) begin
      step(1, 1, 0, 16'h0);
      guard++;
    end
    chk("R6 reached 0x1FE under new period", count, 16'h01FE);
    exp_c = '{16'h01FF, 16'h0200, 16'h0201, 16'h0200, 16'h01FF, 16'h01FE};
    exp_e = '{0, 1, 0, 1, 0, 0};
    exp_p = '{0, 1, 0, 0, 0, 0};
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 0, 16'h0);
      chk("R2 crest sequence", count, exp_c[i]);
      chk("R4 crest ext_trig", ext_trig, exp_e[i]);
      chk("R5 crest pm_up", pm_up, exp_p[i]);
    end
    chk("R3 falling after crest", dir_down, 1'b1);

    // freeze by run low and by enable low
    for (int i = 0; i < 8; i++) step(0, 1, 0, 16'h0);
    for (int i = 0; i < 8; i++) step(1, 0, 0, 16'h0);
    chk("R7 held value", count, 16'h01FE);

    // shrink the period; drain to the next transfer
    step(1, 1, 1, 16'h0001);
    guard = 0;
    while (guard < 3000) begin
      step(1, 1, 0, 16'h0);
      guard++;
      if (m_per == 16'h0001 && m_cnt == 16'h0000) break;
    end
    chk("R3 back to zero rising", {count, dir_down}, {16'h0000, 1'b0});
    // period 1: expect 1,2,1,0
    step(1, 1, 0, 16'h0); chk("R2 period1 crest", count, 16'h0001);
    step(1, 1, 0, 16'h0); chk("R2 period1 peak", count, 16'h0002);
    step(1, 1, 0, 16'h0); chk("R4 period1 falling trig", {count, ext_trig}, {16'h0001, 1'b1});
    step(1, 1, 0, 16'h0); chk("R3 period1 zero", {count, dir_down}, {16'h0000, 1'b0});

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit r, e, w;
      logic [15:0] d;
      r = ($urandom_range(9) != 0);
      e = ($urandom_range(3) != 0);
      w = ($urandom_range(7) == 0);
      d = 16'($urandom_range(20, 1));
      step(r, e, w, d);
    end
    finish_up();
  end
endmodule